// File: doc/BRIEF.md
# Descriptor Ring Doorbell Poller

This block walks a circular ring of 32-bit buffer descriptors for a DMA-style engine. Software rings a doorbell by writing to the block's active register. The data in that write does not matter; the write only raises an active flag. While that flag is set, the engine is enabled and no soft reset is applied, the block reads descriptors one at a time through a request/valid memory port. Each descriptor that carries its ready bit is offered downstream on a valid/ready handshake. The ring position moves on only after the downstream side accepts the descriptor.

When a fetched descriptor is not ready, the hardware clears the active flag itself and polling stops. The ring position is kept, so the next doorbell resumes at the descriptor that stopped the walk. A wrap bit in a descriptor closes the ring: the fetch after it goes back to the ring base address. Clearing the engine enable or asserting the soft reset drops the flag at once and withdraws any descriptor on offer. A soft reset also returns the ring position to the base.

Top module: `ring_doorbell_poller`

## Requirements
- R1: A write with `reg_addr` equal to 0x10 sets the active flag on the next clock edge, whatever the value of `reg_wdata`. A write to any other offset leaves the flag unchanged.
- R2: `reg_rdata` shows the active flag at bit 24, which is bit 7 when bit 0 is taken as the most significant. Every other bit reads as zero.
- R3: `mem_req` is asserted only while the active flag is set, `eng_enable` is high and `soft_reset` is low.
- R4: Each fetch reads address `ring_base` + ring index. A descriptor whose bit 15 (ready) is set is offered on `desc_valid` with its word and address. The offer is held stable until `desc_ready`, and the next fetch starts only after the handshake completes, with the ring index advanced by one.
- R5: A fetched descriptor with bit 15 clear clears the active flag on the clock edge at which the read response is taken. No further fetches are made.
- R6: After a handshake on a descriptor whose bit 13 (wrap) is set, the ring index returns to zero, so the next fetch reads `ring_base`.
- R7: While `eng_enable` is low, the flag is cleared and any offer on `desc_valid` is withdrawn. A write in the same cycle does not set the flag. The ring index is kept.
- R8: While `soft_reset` is high, the flag is cleared, any offer is withdrawn and the ring index returns to zero. A write in the same cycle does not set the flag.
- R9: A low `rst_n` at a clock edge clears the flag and the ring index, and no request or offer is made while it is low.
- R10: A write that lands on the same edge as a not-ready clear keeps the flag set, and the same descriptor is fetched again.
- R11: After polling stops on a not-ready descriptor, the next doorbell resumes the walk at that same descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data; its value is not used |
| reg_rdata | output | 32 | Active register readback |
| eng_enable | input | 1 | Global engine enable |
| soft_reset | input | 1 | Soft reset control |
| ring_base | input | 8 | Word address of the first descriptor |
| mem_req | output | 1 | Descriptor read request, one cycle per fetch |
| mem_addr | output | 8 | Descriptor read address |
| mem_valid | input | 1 | Read response valid, at least one cycle after the request |
| mem_rdata | input | 32 | Read response word |
| desc_valid | output | 1 | Ready descriptor on offer |
| desc_addr | output | 8 | Address of the offered descriptor |
| desc_data | output | 32 | Offered descriptor word |
| desc_ready | input | 1 | Downstream accepts the offer |

## Verification
The walk is tried with three downstream patterns: always ready, pseudo-random stalls and a permanent stall. Together they show that the ring index moves on handshakes and not on offers. One ring stops partway, and a later doorbell must fetch the stopping descriptor first, which separates resuming from restarting. Another ring places its wrap bit mid-ring so that a missing return to the base shows up. A doorbell is timed to coincide with a not-ready response, which separates write priority from clear priority. Disable and soft reset are applied, each with a write in the same cycle, and the next walk starts at the retained position in one case and at the base in the other.

// File: rtl/rdp_pkg.sv
// Package: shared constants and state type for the descriptor ring poller.
// Assumes 32-bit descriptor words with fixed ready and wrap bit positions.
package rdp_pkg;
    localparam int DESC_W    = 32;
    localparam int READY_BIT = 15;
    localparam int WRAP_BIT  = 13;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_REQ,
        PS_WAIT,
        PS_DRAIN,
        PS_SHOW
    } poll_state_e;
endpackage

// File: rtl/rdp_active_flag.sv
// Module: rdp_active_flag
// Holds the doorbell flag. Disable and soft reset dominate, then a software
// write, then the hardware clear raised when a descriptor is not ready.
// Assumes wr_hit is already decoded from the register address.
module rdp_active_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic eng_enable,
    input  logic soft_reset,
    input  logic hw_clear,
    output logic active
);
    // Flag register with its priority order
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= 1'b0;
        else if (!eng_enable || soft_reset)
            active <= 1'b0;
        else if (wr_hit)
            active <= 1'b1;
        else if (hw_clear)
            active <= 1'b0;
    end

    assert_write_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && eng_enable && !soft_reset) |=> active);
    assert_notready_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_clear && !wr_hit) |=> !active);
    assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_enable |=> !active);
    assert_soft_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset |=> !active);
    assert_reset_clears_R9: assert property (@(posedge clk)
        !rst_n |=> !active);
    assert_write_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_clear && wr_hit && eng_enable && !soft_reset) |=> active);
endmodule

// File: rtl/rdp_ring_index.sv
// Module: rdp_ring_index
// Ring position counter. It moves one step on each accepted descriptor and
// goes back to zero after a wrap descriptor or on soft reset. A stop does
// not change it. Assumes advance is a single-cycle pulse.
module rdp_ring_index #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_reset,
    input  logic             advance,
    input  logic             wrap,
    output logic [IDX_W-1:0] idx
);
    // Position update on accept, wrap or soft reset
    always_ff @(posedge clk) begin
        if (!rst_n || soft_reset)
            idx <= '0;
        else if (advance)
            idx <= wrap ? '0 : idx + 1'b1;
    end

    assert_wrap_to_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && wrap && !soft_reset) |=> (idx == '0));
    assert_soft_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset |=> (idx == '0));
    assert_idx_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !soft_reset) |=> $stable(idx));
endmodule

// File: rtl/rdp_poll_fsm.sv
// Module: rdp_poll_fsm
// Fetch sequencer: request, wait for the word, then either offer it or
// report a not-ready clear. A fetch aborted while a read is outstanding is
// drained so that a late response is not taken as a new descriptor.
// Assumes every request is answered exactly once, one or more cycles later.
module rdp_poll_fsm
    import rdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              abort,
    input  logic              mem_valid,
    input  logic [DESC_W-1:0] mem_rdata,
    input  logic              desc_ready,
    output logic              mem_req,
    output logic              desc_valid,
    output logic [DESC_W-1:0] desc_data,
    output logic              hw_clear,
    output logic              advance,
    output logic              wrap_seen
);
    poll_state_e state, nxt;
    logic        take_word;

    // Decode of the read response in the wait state
    always_comb begin
        take_word = (state == PS_WAIT) && mem_valid && !abort &&  mem_rdata[READY_BIT];
        hw_clear  = (state == PS_WAIT) && mem_valid && !abort && !mem_rdata[READY_BIT];
    end

    // Next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            PS_IDLE:  if (run) nxt = PS_REQ;
            PS_REQ:   nxt = abort ? PS_IDLE : PS_WAIT;
            PS_WAIT: begin
                if (mem_valid)  nxt = take_word ? PS_SHOW : PS_IDLE;
                else if (abort) nxt = PS_DRAIN;
            end
            PS_DRAIN: if (mem_valid) nxt = PS_IDLE;
            PS_SHOW:  if (abort || desc_ready) nxt = PS_IDLE;
            default:  nxt = PS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_IDLE;
        else        state <= nxt;
    end

    // Capture of a ready descriptor word
    always_ff @(posedge clk) begin
        if (!rst_n)         desc_data <= '0;
        else if (take_word) desc_data <= mem_rdata;
    end

    // Port-side strobes
    always_comb begin
        mem_req    = (state == PS_REQ) && !abort;
        desc_valid = (state == PS_SHOW) && !abort;
        advance    = desc_valid && desc_ready;
        wrap_seen  = desc_data[WRAP_BIT];
    end

    assert_offer_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && !desc_ready) |=> (abort || (desc_valid && $stable(desc_data))));
    assert_single_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    assert_offer_is_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> desc_data[READY_BIT]);
endmodule

// File: rtl/ring_doorbell_poller.sv
// Module: ring_doorbell_poller (top)
// Decodes the doorbell write, drives the readback word, and connects the
// flag, the ring index and the fetch sequencer. Addresses are word
// addresses; ring_base is expected to stay steady while polling runs.
module ring_doorbell_poller #(
    parameter int                ADDR_W     = 8,
    parameter int                REG_AW     = 8,
    parameter int                REG_W      = 32,
    parameter logic [REG_AW-1:0] ACTIVE_OFS = 'h10,
    parameter int                FLAG_MSB0  = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr_en,
    input  logic [REG_AW-1:0]         reg_addr,
    input  logic [REG_W-1:0]          reg_wdata,
    output logic [REG_W-1:0]          reg_rdata,
    input  logic                      eng_enable,
    input  logic                      soft_reset,
    input  logic [ADDR_W-1:0]         ring_base,
    output logic                      mem_req,
    output logic [ADDR_W-1:0]         mem_addr,
    input  logic                      mem_valid,
    input  logic [rdp_pkg::DESC_W-1:0] mem_rdata,
    output logic                      desc_valid,
    output logic [ADDR_W-1:0]         desc_addr,
    output logic [rdp_pkg::DESC_W-1:0] desc_data,
    input  logic                      desc_ready
);
    localparam int FLAG_LSB0 = REG_W - 1 - FLAG_MSB0;

    logic              wr_hit, active, run, abort;
    logic              hw_clear, advance, wrap_seen;
    logic [ADDR_W-1:0] idx;
    logic              wdata_unused;

    // Doorbell decode and run/abort qualifiers; write data is not used
    always_comb begin
        wr_hit       = reg_wr_en && (reg_addr == ACTIVE_OFS);
        abort        = !eng_enable || soft_reset;
        run          = active && !abort;
        wdata_unused = ^reg_wdata;
    end

    // Readback word with the flag at its fixed position
    always_comb begin
        reg_rdata            = '0;
        reg_rdata[FLAG_LSB0] = active;
    end

    // Descriptor addressing from the ring base and position
    always_comb begin
        mem_addr  = ring_base + idx;
        desc_addr = ring_base + idx;
    end

    rdp_active_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hit     (wr_hit),
        .eng_enable (eng_enable),
        .soft_reset (soft_reset),
        .hw_clear   (hw_clear),
        .active     (active)
    );

    rdp_ring_index #(.IDX_W(ADDR_W)) u_index (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_reset (soft_reset),
        .advance    (advance),
        .wrap       (wrap_seen),
        .idx        (idx)
    );

    rdp_poll_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .abort      (abort),
        .mem_valid  (mem_valid),
        .mem_rdata  (mem_rdata),
        .desc_ready (desc_ready),
        .mem_req    (mem_req),
        .desc_valid (desc_valid),
        .desc_data  (desc_data),
        .hw_clear   (hw_clear),
        .advance    (advance),
        .wrap_seen  (wrap_seen)
    );

    assert_req_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (active && eng_enable && !soft_reset));
    assert_offer_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> (eng_enable && !soft_reset));
    assert_quiet_in_reset_R9: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !desc_valid && reg_rdata == '0));
endmodule

// File: tb/ring_doorbell_poller_test.sv
`timescale 1ns/1ps
module ring_doorbell_poller_test;
    localparam logic [7:0] BASE = 8'h20;
    localparam logic [7:0] OFS  = 8'h10;
    localparam logic [31:0] RDY = 32'h0000_8000;
    localparam logic [31:0] WRP = 32'h0000_2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        eng_enable = 1'b0;
    logic        soft_reset = 1'b0;
    logic [7:0]  ring_base = BASE;
    logic        mem_req;
    logic [7:0]  mem_addr;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = 32'h0;
    logic        desc_valid;
    logic [7:0]  desc_addr;
    logic [31:0] desc_data;
    logic        desc_ready = 1'b0;

    int checks = 0;
    int failures = 0;

    ring_doorbell_poller uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_enable(eng_enable),
        .soft_reset(soft_reset), .ring_base(ring_base), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .desc_valid(desc_valid), .desc_addr(desc_addr), .desc_data(desc_data),
        .desc_ready(desc_ready)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Bench memory and downstream model state
    logic [31:0] bmem [256];
    int          req_cnt [256];
    int          hs_count = 0;
    int          req_count = 0;
    logic [7:0]  last_req = 8'h00;
    bit          pend = 0, collide = 0, wr_pulse = 0;
    logic [7:0]  pend_a = 8'h00;
    int          bp_mode = 0;
    logic [7:0]  lfsr = 8'h5a;

    // Reference model state
    bit          m_flag = 0;
    logic [7:0]  m_idx = 8'h00;
    bit          p_dv = 0;
    logic [7:0]  p_daddr = 8'h00;
    logic [31:0] p_ddata = 32'h0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            bmem[i] = 32'h0;
            req_cnt[i] = 0;
        end
    end

    // Memory responder (one-cycle latency), collision writer, downstream ready
    always begin
        @(negedge clk);
        mem_valid = 1'b0;
        if (wr_pulse) begin
            reg_wr_en = 1'b0;
            wr_pulse = 0;
        end
        if (pend) begin
            mem_valid = 1'b1;
            mem_rdata = bmem[pend_a];
            pend = 0;
            if (collide && !bmem[pend_a][15]) begin
                reg_wr_en = 1'b1;
                reg_addr = OFS;
                collide = 0;
                wr_pulse = 1;
            end
        end
        if (mem_req) begin
            pend = 1;
            pend_a = mem_addr;
        end
        desc_ready = (bp_mode == 0) ? 1'b1 : (bp_mode == 1) ? lfsr[0] : 1'b0;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end

    // Cycle-by-cycle reference model, compared just after every edge
    always begin
        logic [7:0] ea;
        bit hs, wr;
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_flag = 0;
            m_idx = 8'h00;
        end else begin
            hs = p_dv && desc_ready && eng_enable && !soft_reset;
            ea = BASE + m_idx;
            if (hs) begin
                chk(p_daddr == ea, "R4 offer address", {24'h0, p_daddr}, {24'h0, ea});
                chk(p_ddata == bmem[ea], "R4 offer data", p_ddata, bmem[ea]);
                hs_count++;
            end
            wr = reg_wr_en && (reg_addr == OFS);
            if (!eng_enable || soft_reset) m_flag = 0;
            else if (wr) m_flag = 1;
            else if (mem_valid && !mem_rdata[15]) m_flag = 0;
            if (soft_reset) m_idx = 8'h00;
            else if (hs) m_idx = p_ddata[13] ? 8'h00 : m_idx + 8'h01;
        end
        chk(reg_rdata == (m_flag ? 32'h0100_0000 : 32'h0), "R2 readback", reg_rdata,
            m_flag ? 32'h0100_0000 : 32'h0);
        if (mem_req) begin
            ea = BASE + m_idx;
            chk(m_flag, "R3 request with flag", {31'h0, m_flag}, 32'h1);
            chk(mem_addr == ea, "R4 fetch address", {24'h0, mem_addr}, {24'h0, ea});
            req_count++;
            req_cnt[mem_addr]++;
            last_req = mem_addr;
        end
        p_dv = desc_valid;
        p_daddr = desc_addr;
        p_ddata = desc_data;
    end

    task automatic ring_bell(input logic [31:0] d, input logic [7:0] a);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_wdata = 32'h0;
    endtask

    task automatic wait_stop();
        repeat (3) @(negedge clk);
        for (int k = 0; k < 3000 && reg_rdata[24]; k++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(!reg_rdata[24] && !mem_req, "R5 polling stopped", reg_rdata, 32'h0);
    endtask

    // Watchdog
    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int h0, r0, c0;
        repeat (3) @(negedge clk);
        // R9: quiet outputs in reset
        chk(reg_rdata == 32'h0, "R9 reset readback", reg_rdata, 32'h0);
        chk(!mem_req && !desc_valid, "R9 reset strobes", {30'h0, mem_req, desc_valid}, 32'h0);
        rst_n = 1'b1;
        eng_enable = 1'b1;

        // R1: a write to another offset is ignored
        ring_bell(32'hFFFF_FFFF, 8'h14);
        repeat (3) @(negedge clk);
        chk(reg_rdata == 32'h0 && req_count == 0, "R1 other offset", reg_rdata, 32'h0);

        // Phase A: four ready descriptors then a not-ready one, zero write data
        for (int i = 0; i < 4; i++) bmem[BASE + i] = RDY | (32'h1000_0000 * (i + 1));
        bmem[BASE + 4] = 32'h0;
        bp_mode = 0;
        ring_bell(32'h0, OFS);
        chk(reg_rdata == 32'h0100_0000, "R1 zero data sets flag", reg_rdata, 32'h0100_0000);
        wait_stop();
        chk(hs_count == 4, "R4 four offers", hs_count, 4);
        chk(last_req == BASE + 4, "R5 stop descriptor", {24'h0, last_req}, {24'h0, BASE + 8'd4});
        chk(req_cnt[BASE] == 1, "R9 first fetch at base", req_cnt[BASE], 1);
        r0 = req_count;
        repeat (20) @(negedge clk);
        chk(req_count == r0, "R5 no fetch after stop", req_count, r0);

        // Phase B: doorbell while disabled
        eng_enable = 1'b0;
        ring_bell(32'hFFFF_FFFF, OFS);
        repeat (10) @(negedge clk);
        chk(reg_rdata == 32'h0, "R7 write while disabled", reg_rdata, 32'h0);
        chk(req_count == r0, "R3 no fetch while disabled", req_count, r0);
        eng_enable = 1'b1;

        // Phase C: resume at index 4, wrap at 5, random stalls
        bmem[BASE + 4] = RDY | 32'h00AB_0000;
        bmem[BASE + 5] = RDY | WRP | 32'h00CD_0000;
        bmem[BASE + 0] = 32'h0000_2000;
        bp_mode = 1;
        h0 = hs_count;
        c0 = req_cnt[BASE + 4];
        ring_bell(32'hFFFF_FFFF, OFS);
        chk(reg_rdata == 32'h0100_0000, "R2 only flag bit", reg_rdata, 32'h0100_0000);
        wait_stop();
        chk(req_cnt[BASE + 4] - c0 == 1, "R11 resume at stop", req_cnt[BASE + 4] - c0, 1);
        chk(hs_count - h0 == 2, "R11 two offers", hs_count - h0, 2);
        chk(last_req == BASE, "R6 wrap to base", {24'h0, last_req}, {24'h0, BASE});

        // Phase D: doorbell on the same edge as a not-ready clear
        bp_mode = 0;
        c0 = req_cnt[BASE];
        collide = 1;
        ring_bell(32'h1234_5678, OFS);
        wait_stop();
        chk(req_cnt[BASE] - c0 == 2, "R10 refetch on collision", req_cnt[BASE] - c0, 2);

        // Phase E: disable while an offer is stalled
        for (int i = 0; i < 6; i++) bmem[BASE + i] = RDY | (32'h0001_0000 * (i + 1));
        bmem[BASE + 5] = bmem[BASE + 5] | WRP;
        bp_mode = 2;
        ring_bell(32'h0, OFS);
        for (int k = 0; k < 100 && !desc_valid; k++) @(negedge clk);
        chk(desc_valid, "R4 offer held under stall", {31'h0, desc_valid}, 32'h1);
        repeat (3) @(negedge clk);
        chk(desc_valid && desc_addr == BASE, "R4 offer still held", {24'h0, desc_addr}, {24'h0, BASE});
        eng_enable = 1'b0;
        #1;
        chk(!desc_valid, "R7 offer withdrawn", {31'h0, desc_valid}, 32'h0);
        @(negedge clk);
        chk(reg_rdata == 32'h0, "R7 flag cleared", reg_rdata, 32'h0);
        eng_enable = 1'b1;
        bp_mode = 0;
        r0 = req_count;
        repeat (10) @(negedge clk);
        chk(req_count == r0, "R3 idle after disable", req_count, r0);
        bmem[BASE + 2] = 32'h0;
        h0 = hs_count;
        c0 = req_cnt[BASE];
        ring_bell(32'h0, OFS);
        wait_stop();
        chk(req_cnt[BASE] - c0 == 1, "R7 index kept", req_cnt[BASE] - c0, 1);
        chk(hs_count - h0 == 2 && last_req == BASE + 2, "R7 walk after enable", hs_count - h0, 2);

        // Phase F: soft reset with a same-cycle write, then a fresh walk
        @(negedge clk);
        soft_reset = 1'b1;
        reg_wr_en = 1'b1;
        reg_addr = OFS;
        @(negedge clk);
        chk(reg_rdata == 32'h0, "R8 soft reset beats write", reg_rdata, 32'h0);
        soft_reset = 1'b0;
        reg_wr_en = 1'b0;
        h0 = hs_count;
        c0 = req_cnt[BASE];
        ring_bell(32'hA5A5_A5A5, OFS);
        wait_stop();
        chk(req_cnt[BASE] - c0 == 1, "R8 index back to base", req_cnt[BASE] - c0, 1);
        chk(hs_count - h0 == 2, "R8 walk from base", hs_count - h0, 2);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule